// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

The block watches a vector of debounced digital inputs and records selected transitions as sticky change flags. For every input bit a polarity setting chooses the edge that counts: a falling edge or a rising one. A flag stays set until the host removes it. The host can remove it in three ways: write-one-to-clear on single bits, a clear of the low or high byte, or a master clear.

A per-bit enable mask routes the flags into an interrupt line. That line is also combined with an overflow request from a neighbouring event counter. A status word gives the enabled activity of each byte, the overflow request and the combined interrupt. The master clear and a dedicated control bit also send a one-cycle clear pulse back to the counter that owns the overflow status.

The host reaches the block through a flat four-word register port. A write lasts one clock. Reads are combinational.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset the flags, enable mask and polarity mask all read as zero, the status reads zero with `ovf_irq_i` low, and `irq_o` is low.
- R2: Polarity bit 0 makes a high-to-low change of that input set its flag; polarity bit 1 makes a low-to-high change set it; the opposite change leaves the flag alone. The flag reads as set after the first rising clock edge at which the new input level is sampled.
- R3: A set flag holds its value across any number of cycles until a clear addresses it.
- R4: A write to address 1 clears every flag whose data bit is 1; data bits at 0, and ones aimed at flags already clear, change nothing.
- R5: `irq_o` is high exactly when some flag and its enable bit are both 1, or `ovf_irq_i` is high.
- R6: A write to address 0 with data bit 0 clears flags 7..0, and with data bit 1 clears flags 15..8, whatever the enable mask holds. These bits act only in the write cycle, so a later edge sets its flag again.
- R7: A write to address 0 with data bit 4 clears all flags and raises `ovf_clr_o` during that write cycle. Data bit 3 raises `ovf_clr_o` alone and leaves the flags untouched.
- R8: Reading address 0 gives the status word: bit 0 is the enabled activity of flags 7..0, bit 1 the same for flags 15..8, bit 3 follows `ovf_irq_i`, bit 4 equals `irq_o`, and all other bits are 0.
- R9: When a flag's edge and a clear of that flag fall in the same cycle, the flag ends up set.
- R10: The first clock after reset only records the input levels, so no flag is set by a difference between the input and any reset value.
- R11: Address 2 holds the enable mask and address 3 holds the polarity mask. Both read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 16 | Debounced input vector |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for `addr_i` (combinational) |
| ovf_irq_i | input | 1 | Overflow interrupt request from the event counter |
| ovf_clr_o | output | 1 | One-cycle clear pulse for the overflow status |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A flag is due one rising edge after the input change is presented. The bench drives inputs on the falling edge, so the flag must show half a cycle after the next rising edge. `irq_o` and the status word depend combinationally on the flags and the masks, so they are checked in that same sampling slot. `ovf_clr_o` is due inside the write cycle itself and is sampled before the rising edge that ends the write. Reads are combinational: each read sets the address after a falling edge and samples a short delay later. A cycle-level bench model runs the same edge, set and clear rules in parallel.

// File: rtl/cos_irq_pkg.sv
package cos_irq_pkg;

   typedef enum logic [1:0] {
      A_CTRL     = 2'd0,
      A_FLAGS    = 2'd1,
      A_ENABLE   = 2'd2,
      A_POLARITY = 2'd3
   } cos_addr_e;

   // control word bits (write to A_CTRL); byte clears occupy bits [NBYTES-1:0]
   localparam int CTL_CLR_OVF = 3;
   localparam int CTL_CLR_ALL = 4;

   // status word bits (read of A_CTRL); byte status occupies bits [NBYTES-1:0]
   localparam int ST_OVF    = 3;
   localparam int ST_MASTER = 4;

   localparam int BYTE_W    = 8;
   localparam int MAX_BYTES = 2;

endpackage

// File: rtl/cos_edge_detect.sv
module cos_edge_detect #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] din_i,
   input  logic [W-1:0] pol_i,
   output logic [W-1:0] set_o
);

   logic [W-1:0] prev_q;
   logic         armed_q;

   // first clock after reset only captures levels
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q  <= '1;
         armed_q <= 1'b0;
      end else begin
         prev_q  <= din_i;
         armed_q <= 1'b1;
      end
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign set_o[i] = armed_q & (pol_i[i] ? (~prev_q[i] &  din_i[i])
                                            : ( prev_q[i] & ~din_i[i]));
   end

endmodule

// File: rtl/cos_flag_bank.sv
module cos_flag_bank #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] flags_o
);

   logic [W-1:0] flags_q;

   // set wins over clear so no event is lost
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q <= '0;
      else         flags_q <= (flags_q & ~clr_i) | set_i;
   end

   assign flags_o = flags_q;

   // R2, R9: a detected edge always lands in its flag
   p_set_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));

   // R3: flags not addressed by a clear keep their value
   p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((flags_q & ~clr_i) != '0) |=>
         ((flags_q & $past(flags_q & ~clr_i)) == $past(flags_q & ~clr_i)));

endmodule

// File: rtl/cos_regs.sv
module cos_regs
   import cos_irq_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_en_i,
   input  logic [1:0]   addr_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] flags_i,
   input  logic         ovf_irq_i,
   output logic [W-1:0] en_o,
   output logic [W-1:0] pol_o,
   output logic [W-1:0] clr_o,
   output logic         ovf_clr_o,
   output logic         irq_o,
   output logic [W-1:0] rdata_o
);

   localparam int NBYTES = W / BYTE_W;

   logic [W-1:0]      en_q, pol_q, byte_mask, status;
   logic [NBYTES-1:0] byte_irq;
   logic              ctl_wr, flg_wr;

   assign ctl_wr = wr_en_i && (addr_i == A_CTRL);
   assign flg_wr = wr_en_i && (addr_i == A_FLAGS);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q  <= '0;
         pol_q <= '0;
      end else if (wr_en_i) begin
         if (addr_i == A_ENABLE)   en_q  <= wdata_i;
         if (addr_i == A_POLARITY) pol_q <= wdata_i;
      end
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign byte_mask[b*BYTE_W +: BYTE_W] = {BYTE_W{ctl_wr & wdata_i[b]}};
      assign byte_irq[b] = |(flags_i[b*BYTE_W +: BYTE_W] & en_q[b*BYTE_W +: BYTE_W]);
   end

   // clear pulses exist only for the write cycle
   assign clr_o     = (flg_wr ? wdata_i : '0) | byte_mask
                    | {W{ctl_wr & wdata_i[CTL_CLR_ALL]}};
   assign ovf_clr_o = ctl_wr & (wdata_i[CTL_CLR_OVF] | wdata_i[CTL_CLR_ALL]);
   assign irq_o     = (|byte_irq) | ovf_irq_i;

   always_comb begin
      status                = '0;
      status[NBYTES-1:0]    = byte_irq;
      status[ST_OVF]        = ovf_irq_i;
      status[ST_MASTER]     = irq_o;
   end

   always_comb begin
      case (addr_i)
         A_CTRL:   rdata_o = status;
         A_FLAGS:  rdata_o = flags_i;
         A_ENABLE: rdata_o = en_q;
         default:  rdata_o = pol_q;
      endcase
   end

   assign en_o  = en_q;
   assign pol_o = pol_q;

   // R7: master clear always requests the overflow clear
   p_master_ovf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == A_CTRL && wdata_i[CTL_CLR_ALL]) |-> ovf_clr_o);

endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
   import cos_irq_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] din_i,
   input  logic              wr_en_i,
   input  logic [1:0]        addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              ovf_irq_i,
   output logic              ovf_clr_o,
   output logic              irq_o
);

   localparam int NBYTES = DATA_W / BYTE_W;

   if ((DATA_W % BYTE_W) != 0 || NBYTES < 1 || NBYTES > MAX_BYTES) begin : g_bad_width
      $error("cos_irq_ctrl: DATA_W must be 8 or 16");
   end

   logic [DATA_W-1:0] set_vec, clr_vec, flags, en, pol;
   logic              irq_comb;

   cos_edge_detect #(.W(DATA_W)) i_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .din_i (din_i),
      .pol_i (pol),
      .set_o (set_vec)
   );

   cos_flag_bank #(.W(DATA_W)) i_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec),
      .clr_i  (clr_vec),
      .flags_o(flags)
   );

   cos_regs #(.W(DATA_W)) i_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i),
      .addr_i   (addr_i),
      .wdata_i  (wdata_i),
      .flags_i  (flags),
      .ovf_irq_i(ovf_irq_i),
      .en_o     (en),
      .pol_o    (pol),
      .clr_o    (clr_vec),
      .ovf_clr_o(ovf_clr_o),
      .irq_o    (irq_comb),
      .rdata_o  (rdata_o)
   );

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_q <= 1'b0;
         else         irq_q <= irq_comb;
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = irq_comb;
      // R5: nothing enabled and no overflow request means a quiet line
      p_masked_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (en == '0 && !ovf_irq_i) |-> !irq_o);
   end

   // R6: a low-byte clear without a competing edge empties the low byte
   p_byte_wipe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == A_CTRL && wdata_i[0] && set_vec[BYTE_W-1:0] == '0)
         |=> (flags[BYTE_W-1:0] == '0));

   // R7: a master clear without a competing edge empties every flag
   p_master_wipe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == A_CTRL && wdata_i[CTL_CLR_ALL] && set_vec == '0)
         |=> (flags == '0));

endmodule

// File: tb/test_cos_irq_ctrl.sv
`timescale 1ns/1ps
module test_cos_irq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] din = '0;
   logic        wr = 1'b0;
   logic [1:0]  addr = '0;
   logic [15:0] wd = '0;
   logic [15:0] rdata;
   logic        ovf = 1'b0;
   logic        ovf_clr;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   cos_irq_ctrl i_cos_irq_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .din_i(din), .wr_en_i(wr), .addr_i(addr),
      .wdata_i(wd), .rdata_o(rdata), .ovf_irq_i(ovf), .ovf_clr_o(ovf_clr), .irq_o(irq)
   );

   // bench model
   logic [15:0] m_flags, m_en, m_pol, m_prev;
   bit          m_armed;

   function automatic logic [15:0] f_edges(input logic [15:0] d);
      if (!m_armed) return '0;
      return (m_pol & ~m_prev & d) | (~m_pol & m_prev & ~d);
   endfunction

   function automatic logic [15:0] f_clr(input logic w, input logic [1:0] a, input logic [15:0] v);
      logic [15:0] c = '0;
      if (w && a == 2'd1) c = v;
      if (w && a == 2'd0) begin
         if (v[0]) c[7:0]  = 8'hFF;
         if (v[1]) c[15:8] = 8'hFF;
         if (v[4]) c = 16'hFFFF;
      end
      return c;
   endfunction

   function automatic logic f_irq();
      return (|(m_flags & m_en)) | ovf;
   endfunction

   function automatic logic [15:0] f_status();
      logic [15:0] s = '0;
      s[0] = |(m_flags[7:0] & m_en[7:0]);
      s[1] = |(m_flags[15:8] & m_en[15:8]);
      s[3] = ovf;
      s[4] = f_irq();
      return s;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // one clock with the inputs already set; checks ovf_clr in-cycle and irq after the edge
   task automatic tick(input string req);
      logic [15:0] nf;
      #0.5;
      chk({req, "/R7 ovf_clr"}, {15'b0, ovf_clr},
          {15'b0, wr && addr == 2'd0 && (wd[3] || wd[4])});
      nf = (m_flags & ~f_clr(wr, addr, wd)) | f_edges(din);
      @(posedge clk);
      if (wr && addr == 2'd2) m_en  = wd;
      if (wr && addr == 2'd3) m_pol = wd;
      m_flags = nf;
      m_prev  = din;
      m_armed = 1'b1;
      @(negedge clk);
      #0.5;
      chk({req, "/R5 irq"}, {15'b0, irq}, {15'b0, f_irq()});
   endtask

   task automatic drive(input string req, input logic w, input logic [1:0] a,
                        input logic [15:0] v, input logic [15:0] d);
      wr = w; addr = a; wd = v; din = d;
      tick(req);
      wr = 1'b0;
   endtask

   task automatic rd_all(input string req);
      wr = 1'b0;
      addr = 2'd0; #0.2; chk({req, "/R8 status"}, rdata, f_status());
      addr = 2'd1; #0.2; chk({req, "/R3 flags"}, rdata, m_flags);
      addr = 2'd2; #0.2; chk({req, "/R11 enable"}, rdata, m_en);
      addr = 2'd3; #0.2; chk({req, "/R11 polarity"}, rdata, m_pol);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] d;
      void'($urandom(32'h5EED_C05A));
      m_flags = '0; m_en = '0; m_pol = '0; m_prev = '0; m_armed = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1; #0.5;

      // R1: reset state
      rd_all("R1");
      chk("R1 rdata status literal", rdata, 16'h0000);
      chk("R1 irq", {15'b0, irq}, 16'h0000);

      // R10: inputs low through reset, first clocks must not set anything
      drive("R10", 1'b0, 2'd0, 16'h0, 16'h0000);
      drive("R10", 1'b0, 2'd0, 16'h0, 16'h0000);
      addr = 2'd1; #0.2; chk("R10 no flag from reset value", rdata, 16'h0000);

      // R2/R11: enable all, polarity 0 (falling edge counts)
      drive("R11", 1'b1, 2'd2, 16'hFFFF, 16'h0000);
      drive("R2 rise ignored", 1'b0, 2'd0, 16'h0, 16'h0001);
      addr = 2'd1; #0.2; chk("R2 rise with pol0 ignored", rdata, 16'h0000);
      drive("R2 fall", 1'b0, 2'd0, 16'h0, 16'h0000);
      addr = 2'd1; #0.2; chk("R2 fall with pol0 sets bit0", rdata, 16'h0001);
      drive("R11", 1'b1, 2'd3, 16'h0002, 16'h0000);
      drive("R2 rise", 1'b0, 2'd0, 16'h0, 16'h0002);
      addr = 2'd1; #0.2; chk("R2 rise with pol1 sets bit1", rdata, 16'h0003);
      drive("R2 fall ignored", 1'b0, 2'd0, 16'h0, 16'h0000);
      rd_all("R2");

      // R3: hold
      for (int i = 0; i < 5; i++) drive("R3", 1'b0, 2'd0, 16'h0, 16'h0000);
      addr = 2'd1; #0.2; chk("R3 sticky", rdata, 16'h0003);

      // R4: write-one-to-clear
      drive("R4 zeros", 1'b1, 2'd1, 16'h0000, 16'h0000);
      drive("R4 clear bit", 1'b1, 2'd1, 16'h0004, 16'h0000);
      addr = 2'd1; #0.2; chk("R4 no effect", rdata, 16'h0003);
      drive("R4", 1'b1, 2'd1, 16'h0001, 16'h0000);
      addr = 2'd1; #0.2; chk("R4 bit0 cleared", rdata, 16'h0002);

      // R6/R5: byte clears with mask off
      drive("R6", 1'b1, 2'd2, 16'h0000, 16'h1008);
      drive("R6", 1'b0, 2'd0, 16'h0, 16'h0000);
      addr = 2'd1; #0.2; chk("R6 flags 3 and 12 set", rdata, 16'h100A);
      chk("R5 masked irq low", {15'b0, irq}, 16'h0000);
      drive("R6 low clear", 1'b1, 2'd0, 16'h0001, 16'h0000);
      addr = 2'd1; #0.2; chk("R6 low byte cleared", rdata, 16'h1000);
      drive("R6 high clear", 1'b1, 2'd0, 16'h0002, 16'h0000);
      addr = 2'd1; #0.2; chk("R6 high byte cleared", rdata, 16'h0000);
      drive("R6 re-arm", 1'b0, 2'd0, 16'h0, 16'h0008);
      drive("R6 re-set", 1'b0, 2'd0, 16'h0, 16'h0000);
      addr = 2'd1; #0.2; chk("R6 flag sets after clear", rdata, 16'h0008);

      // R8: per-byte status and overflow
      drive("R8", 1'b1, 2'd2, 16'h0100, 16'h0100);
      drive("R8", 1'b0, 2'd0, 16'h0, 16'h0000);
      addr = 2'd0; #0.2; chk("R8 high byte status", rdata, 16'h0012);
      ovf = 1'b1;
      drive("R8 ovf", 1'b1, 2'd2, 16'h0000, 16'h0000);
      addr = 2'd0; #0.2; chk("R8 ovf status", rdata, 16'h0018);
      chk("R5 ovf drives irq", {15'b0, irq}, 16'h0001);
      ovf = 1'b0;

      // R7: overflow clear alone, then master clear
      drive("R7 ovf only", 1'b1, 2'd0, 16'h0008, 16'h0000);
      addr = 2'd1; #0.2; chk("R7 flags kept", rdata, 16'h0108);
      drive("R7 master", 1'b1, 2'd0, 16'h0010, 16'h0000);
      addr = 2'd1; #0.2; chk("R7 master clears all", rdata, 16'h0000);

      // R9: edge meets clear in the same cycle
      drive("R9", 1'b0, 2'd0, 16'h0, 16'h0020);
      drive("R9 w1c race", 1'b1, 2'd1, 16'h0020, 16'h0000);
      addr = 2'd1; #0.2; chk("R9 set beats w1c", rdata, 16'h0020);
      drive("R9", 1'b0, 2'd0, 16'h0, 16'h0020);
      drive("R9 master race", 1'b1, 2'd0, 16'h0010, 16'h0000);
      addr = 2'd1; #0.2; chk("R9 set beats master clear", rdata, 16'h0020);

      // random phase
      d = din;
      for (int i = 0; i < 600; i++) begin
         logic        w;
         logic [1:0]  a;
         logic [15:0] v;
         d   = d ^ ($urandom() & $urandom() & 16'hFFFF);
         w   = ($urandom() % 3) == 0;
         a   = 2'($urandom());
         v   = 16'($urandom());
         if (a == 2'd0 && ($urandom() % 2) == 0) v = v & 16'h0008;
         ovf = ($urandom() % 8) == 0;
         drive("rand R2-R9", w, a, v, d);
         rd_all("rand");
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule